// File: doc/BRIEF.md
# Pair-and-Spare Lockstep Comparator

This block watches two processor pairs: an active pair that drives the system and a hot-spare pair that runs the same workload in the background. Each pair has a primary member and a checker member that execute the same instruction stream. The checker is deliberately skewed one cycle late. The comparator therefore registers each primary output bus for one cycle and compares it with the checker bus that arrives in the next cycle. The forwarded result is the delayed primary word of the selected pair, and it is released only in a cycle where that pair's comparison is clean.

When the active pair disagrees with itself, both of its members are retired together through a sticky untrusted flag. The outputs then move to the spare pair, whose state is already current because it has been running all along, and a single-cycle switchover event is raised. If no trustworthy spare remains when the active pair fails, the block enters a sticky fatal condition and stops forwarding. Everything inside, including the delay registers, is cleared by reset, so the two copies of the comparator state always start out identical.

The processors cannot be stalled, so the output has no ready input and applies no back-pressure. A consumer must take every word that is presented with `out_valid` high, in the cycle it is presented.

Top module: `pairspare_lockstep`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `active_sel`, `pair_untrusted`, `fatal` and `switch_pulse` are all 0.
- R2: A pair miscompares in cycle t only when its primary valid was 1 in cycle t-1, its checker valid is 1 in cycle t, and the primary data of t-1 differs from the checker data of t. A difference while either valid is low has no effect.
- R3: A miscompare of pair i in cycle t sets `pair_untrusted[i]` from cycle t+1. The flag stays set until reset.
- R4: In cycle t, `out_data` is the primary data of the selected pair from cycle t-1. `out_valid` is 1 only when that pair's delayed primary valid and checker valid are both 1, the pair does not miscompare in cycle t, and `fatal` is 0.
- R5: A miscompare of pair 0 while pair 0 is selected, with pair 1 trusted and not miscomparing in the same cycle t, makes `active_sel` 1 from cycle t+1 and raises `switch_pulse` in cycle t+1 only. `active_sel` encodes pair 0 as 0 and pair 1 as 1.
- R6: A miscompare of pair 1 while pair 1 is selected raises `fatal` from the next cycle. `fatal` is sticky until reset and forces `out_valid` to 0.
- R7: A miscompare of pair 1 while pair 0 is selected only sets `pair_untrusted[1]`. It causes no switch, no pulse and no change to the output.
- R8: If pair 0 miscompares while selected and pair 1 is already untrusted or miscompares in the same cycle, `fatal` rises in the next cycle, `active_sel` stays 0 and no pulse is raised.
- R9: After a switchover, further miscompares of the retired pair 0 leave `out_data`, `out_valid`, `active_sel` and `fatal` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_data | input | 2 x DW | Primary member output bus, one per pair (index 0 active, 1 spare) |
| prim_valid | input | 2 | Primary member valid, one per pair |
| chk_data | input | 2 x DW | Checker member output bus, one cycle behind the primary |
| chk_valid | input | 2 | Checker member valid, one per pair |
| out_data | output | DW | Delayed primary word of the selected pair |
| out_valid | output | 1 | Forwarded word is checked and usable |
| active_sel | output | 1 | Selected pair: 0 active, 1 spare |
| pair_untrusted | output | 2 | Sticky per-pair retirement flags (both members of the pair) |
| switch_pulse | output | 1 | One-cycle switchover event |
| fatal | output | 1 | Sticky: no trusted pair remains |

## Verification
Some properties are checked by assertions on every cycle. These cover the following: a qualified miscompare seen at the ports always sets the matching untrusted flag, and untrusted and fatal never clear. A switchover pulse lasts one cycle and coincides with a retired pair 0 and a selected spare, and no valid word ever leaves an untrusted pair or a fatal block. Other behaviour can only be shown by the bench's scenarios. This covers the exact data forwarded, the effect of faults injected while the spare is on standby, simultaneous failures of both pairs, and later faults of a retired pair, all compared against a cycle model under random data and valid patterns.

// File: rtl/pairspare_pkg.sv
package pairspare_pkg;
  localparam int NPAIRS    = 2;
  localparam int SEL_W     = 1;
  localparam int IDX_MAIN  = 0;
  localparam int IDX_SPARE = 1;

  typedef enum logic [1:0] {
    PS_ON_MAIN  = 2'd0,
    PS_ON_SPARE = 2'd1,
    PS_HALTED   = 2'd2
  } ps_state_e;
endpackage

// File: rtl/ps_pair_compare.sv
module ps_pair_compare #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prim_data,
  input  logic          prim_valid,
  input  logic [DW-1:0] chk_data,
  input  logic          chk_valid,
  output logic [DW-1:0] dly_data,
  output logic          dly_valid,
  output logic          miscmp,
  output logic          untrusted
);
  logic [DW-1:0] skew_data_q;
  logic          skew_valid_q;
  logic          bad_q;

  // realign primary with the one-cycle-late checker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_data_q  <= '0;
      skew_valid_q <= 1'b0;
    end else begin
      skew_data_q  <= prim_data;
      skew_valid_q <= prim_valid;
    end
  end

  always_comb begin
    miscmp = skew_valid_q && chk_valid && (skew_data_q != chk_data);
  end

  // sticky retirement of both members
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else if (miscmp) bad_q <= 1'b1;
  end

  assign dly_data  = skew_data_q;
  assign dly_valid = skew_valid_q && chk_valid;
  assign untrusted = bad_q;
endmodule

// File: rtl/ps_switch_ctrl.sv
module ps_switch_ctrl
  import pairspare_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAIRS-1:0] miscmp,
  input  logic [NPAIRS-1:0] untrusted,
  output logic [SEL_W-1:0]  sel,
  output logic              fatal,
  output logic              switch_pulse
);
  ps_state_e state_q, state_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    pulse_d = 1'b0;
    unique case (state_q)
      PS_ON_MAIN: begin
        if (miscmp[IDX_MAIN]) begin
          if (!untrusted[IDX_SPARE] && !miscmp[IDX_SPARE]) begin
            state_d = PS_ON_SPARE;
            sel_d   = SEL_W'(IDX_SPARE);
            pulse_d = 1'b1;
          end else begin
            state_d = PS_HALTED;
          end
        end
      end
      PS_ON_SPARE: begin
        if (miscmp[IDX_SPARE]) state_d = PS_HALTED;
      end
      default: state_d = PS_HALTED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_ON_MAIN;
      sel_q   <= SEL_W'(IDX_MAIN);
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      pulse_q <= pulse_d;
    end
  end

  assign sel          = sel_q;
  assign fatal        = (state_q == PS_HALTED);
  assign switch_pulse = pulse_q;
endmodule

// File: rtl/ps_out_mux.sv
module ps_out_mux
  import pairspare_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [NPAIRS-1:0][DW-1:0] dly_data,
  input  logic [NPAIRS-1:0]         dly_valid,
  input  logic [NPAIRS-1:0]         miscmp,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      fatal,
  output logic [DW-1:0]             out_data,
  output logic                      out_valid
);
  always_comb begin
    out_data  = dly_data[sel];
    out_valid = dly_valid[sel] && !miscmp[sel] && !fatal;
  end
endmodule

// File: rtl/pairspare_lockstep.sv
module pairspare_lockstep
  import pairspare_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPAIRS-1:0][DW-1:0] prim_data,
  input  logic [NPAIRS-1:0]         prim_valid,
  input  logic [NPAIRS-1:0][DW-1:0] chk_data,
  input  logic [NPAIRS-1:0]         chk_valid,
  output logic [DW-1:0]             out_data,
  output logic                      out_valid,
  output logic [SEL_W-1:0]          active_sel,
  output logic [NPAIRS-1:0]         pair_untrusted,
  output logic                      switch_pulse,
  output logic                      fatal
);
  logic [NPAIRS-1:0][DW-1:0] dly_data;
  logic [NPAIRS-1:0]         dly_valid;
  logic [NPAIRS-1:0]         miscmp;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    ps_pair_compare #(.DW(DW)) cmp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .prim_data  (prim_data[p]),
      .prim_valid (prim_valid[p]),
      .chk_data   (chk_data[p]),
      .chk_valid  (chk_valid[p]),
      .dly_data   (dly_data[p]),
      .dly_valid  (dly_valid[p]),
      .miscmp     (miscmp[p]),
      .untrusted  (pair_untrusted[p])
    );
  end

  ps_switch_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .miscmp       (miscmp),
    .untrusted    (pair_untrusted),
    .sel          (active_sel),
    .fatal        (fatal),
    .switch_pulse (switch_pulse)
  );

  ps_out_mux #(.DW(DW)) mux_i (
    .dly_data  (dly_data),
    .dly_valid (dly_valid),
    .miscmp    (miscmp),
    .sel       (active_sel),
    .fatal     (fatal),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/ps_lockstep_checker.sv
module ps_lockstep_checker
  import pairspare_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPAIRS-1:0][DW-1:0] prim_data,
  input logic [NPAIRS-1:0]         prim_valid,
  input logic [NPAIRS-1:0][DW-1:0] chk_data,
  input logic [NPAIRS-1:0]         chk_valid,
  input logic                      out_valid,
  input logic [SEL_W-1:0]          active_sel,
  input logic [NPAIRS-1:0]         pair_untrusted,
  input logic                      switch_pulse,
  input logic                      fatal
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_chk
    a_r3_miscompare_retires: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(prim_valid[p]) && chk_valid[p] && ($past(prim_data[p]) != chk_data[p]))
      |=> pair_untrusted[p]);
    a_r3_untrusted_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      pair_untrusted[p] |=> pair_untrusted[p]);
  end

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);
  a_r5_pulse_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (active_sel == SEL_W'(IDX_SPARE)) && pair_untrusted[IDX_MAIN]);
  a_r6_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  a_r6_fatal_blocks_output: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> !out_valid);
  a_r4_no_untrusted_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !pair_untrusted[active_sel]);
  a_r8_no_pulse_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> !fatal);
endmodule

bind pairspare_lockstep ps_lockstep_checker #(.DW(DW)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .prim_data      (prim_data),
  .prim_valid     (prim_valid),
  .chk_data       (chk_data),
  .chk_valid      (chk_valid),
  .out_valid      (out_valid),
  .active_sel     (active_sel),
  .pair_untrusted (pair_untrusted),
  .switch_pulse   (switch_pulse),
  .fatal          (fatal)
);

// File: tb/pairspare_lockstep_tb_top.sv
module pairspare_lockstep_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0][DW-1:0] prim_data = '0;
  logic [1:0]         prim_valid = '0;
  logic [1:0][DW-1:0] chk_data = '0;
  logic [1:0]         chk_valid = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic [0:0]    active_sel;
  logic [1:0]    pair_untrusted;
  logic          switch_pulse;
  logic          fatal;

  pairspare_lockstep #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .prim_data(prim_data), .prim_valid(prim_valid),
    .chk_data(chk_data), .chk_valid(chk_valid),
    .out_data(out_data), .out_valid(out_valid),
    .active_sel(active_sel), .pair_untrusted(pair_untrusted),
    .switch_pulse(switch_pulse), .fatal(fatal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state derived from the requirements
  logic [1:0][DW-1:0] m_pd;
  logic [1:0]         m_pv;
  logic [1:0]         m_bad;
  logic               m_sel, m_fatal, m_pulse;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic mis_of(int p);
    return m_pv[p] && chk_valid[p] && (m_pd[p] != chk_data[p]);
  endfunction

  function automatic logic exp_ovalid();
    return !m_fatal && m_pv[m_sel] && chk_valid[m_sel] && !mis_of(int'(m_sel));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    prim_data = '0; prim_valid = '0; chk_data = '0; chk_valid = '0;
    m_pd = '0; m_pv = '0; m_bad = '0; m_sel = 0; m_fatal = 0; m_pulse = 0;
    repeat (2) @(negedge clk);
    #2;
    // R1 reset state
    check("R1", "out_valid", DW'(out_valid), '0);
    check("R1", "active_sel", DW'(active_sel), '0);
    check("R1", "untrusted", DW'(pair_untrusted), '0);
    check("R1", "fatal", DW'(fatal), '0);
    check("R1", "switch_pulse", DW'(switch_pulse), '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // run n cycles; fault_at[p] = cycle index where pair p's checker is corrupted
  task automatic run(int n, int fa0, int fa1, int vpct, int rand_pm);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        prim_data[p]  = $urandom;
        prim_valid[p] = (($urandom % 100) < vpct);
        if (m_pv[p]) begin
          chk_valid[p] = 1'b1;
          chk_data[p]  = m_pd[p];
        end else begin
          // R2: garbage with delayed primary invalid must be ignored
          chk_valid[p] = $urandom % 2;
          chk_data[p]  = $urandom;
        end
        if ((p == 0 && c == fa0) || (p == 1 && c == fa1) ||
            (($urandom % 1000) < rand_pm))
          chk_data[p] = chk_data[p] ^ (DW'(1) << ($urandom % DW));
        if (m_pv[p] && ($urandom % 100) < 3 && vpct < 100) begin
          chk_valid[p] = 1'b0;  // R2: checker invalid, differing data ignored
          chk_data[p]  = ~m_pd[p];
        end
      end
      #2;
      check("R4", "out_valid", DW'(out_valid), DW'(exp_ovalid()));
      if (exp_ovalid()) check("R4", "out_data", out_data, m_pd[m_sel]);
      check("R5", "active_sel", DW'(active_sel), DW'(m_sel));
      check("R5", "switch_pulse", DW'(switch_pulse), DW'(m_pulse));
      check("R3", "untrusted", DW'(pair_untrusted), DW'(m_bad));
      check("R6", "fatal", DW'(fatal), DW'(m_fatal));
      @(posedge clk);
      begin
        logic mi0, mi1;
        mi0 = mis_of(0); mi1 = mis_of(1);
        m_pulse = 0;
        if (!m_fatal) begin
          if (!m_sel && mi0) begin
            if (!m_bad[1] && !mi1) begin m_sel = 1; m_pulse = 1; end
            else m_fatal = 1;
          end else if (m_sel && mi1) m_fatal = 1;
        end
        m_bad = m_bad | {mi1, mi0};
        m_pd = prim_data;
        m_pv = prim_valid;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // clean traffic with sparse valids: no retirement (R2, R4)
    do_reset();
    run(400, -1, -1, 70, 0);
    check("R2", "no spurious retirement", DW'(pair_untrusted), '0);

    // switchover, retired pair faults, then spare fault (R5, R9, R6)
    do_reset();
    run(50, 20, -1, 100, 0);
    check("R5", "switched to spare", DW'(active_sel), 1);
    run(40, 10, -1, 100, 0);
    check("R9", "retired pair fault harmless", DW'(fatal), 0);
    check("R9", "still on spare", DW'(active_sel), 1);
    run(30, -1, 5, 100, 0);
    check("R6", "fatal after spare fault", DW'(fatal), 1);
    check("R6", "output blocked", DW'(out_valid), 0);

    // spare fails on standby, then active fails (R7, R8)
    do_reset();
    run(30, -1, 10, 100, 0);
    check("R7", "spare retired on standby", DW'(pair_untrusted), 2);
    check("R7", "no switch", DW'(active_sel), 0);
    check("R7", "no halt", DW'(fatal), 0);
    run(30, 10, -1, 100, 0);
    check("R8", "halt without spare", DW'(fatal), 1);
    check("R8", "selection kept", DW'(active_sel), 0);

    // simultaneous failure of both pairs (R8)
    do_reset();
    run(40, 15, 15, 100, 0);
    check("R8", "simultaneous halt", DW'(fatal), 1);
    check("R8", "both retired", DW'(pair_untrusted), 3);

    // random fault episodes
    for (int e = 0; e < 8; e++) begin
      do_reset();
      run(600, -1, -1, 85, 4);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule